// File: doc/BRIEF.md
# Dual-Mode Up/Down Counter with Direction Tracking

This block counts single-cycle up and down strobes into either two independent 8-bit channels or one 16-bit channel. Each channel has a count value and a reload/compare value. It keeps three kinds of status for each channel:

- a two-bit code for the direction of the last count;
- a sticky flag that records a reversal of direction, which can drive an interrupt request;
- a compare flag.

Typical use is position tracking from a pair of already-decoded motion strobes. Software reads the direction code and the reversal flag to learn which way the position moved. It uses the compare flag to detect that a target position was reached while moving upward.

Each channel's direction tracking is a four-state machine whose state is also the direction code. The states are:

- DIR_NONE (00): no count yet.
- DIR_DOWN (01).
- DIR_UP (10).
- DIR_BOTH (11): up and down strobes came in the same cycle.

The transitions are:

- FIRST_COUNT: DIR_NONE to any other state.
- REVERSE_UP: DIR_DOWN to DIR_UP. It raises the reversal flag.
- REVERSE_DOWN: DIR_UP to DIR_DOWN. It raises the reversal flag.
- TO_BOTH: any state to DIR_BOTH.
- LEAVE_BOTH: DIR_BOTH to DIR_UP or DIR_DOWN. It does not count as a reversal.
- HOLD: no count event while running, or the channel is stopped.

Top module: `updn_pair_counter`

## Requirements
- R1: After reset, `count_val` is 0, both direction codes are 00, and all flags and interrupt requests are 0.
- R2: An up strobe alone on a running channel adds one to its count. The count wraps from 255 to 0 in 8-bit mode and from 65535 to 0 in 16-bit mode.
- R3: A down strobe alone subtracts one. A down strobe at zero loads the channel's reload value in that same cycle instead of wrapping.
- R4: When up and down strobes arrive together on a running channel, the count does not change and the direction code becomes 11.
- R5: After an up-only event the direction code is 10; after a down-only event it is 01. The code and count hold when there is no event. Strobes on a channel whose `run` bit is 0 change nothing.
- R6: The reversal flag sets on a down-only event while the code is 10, and on an up-only event while the code is 01. Events from code 00 or 11 never set it. Once set, it stays set until its clear strobe is pulsed. A set in the same cycle as a clear leaves it set.
- R7: `irq[n]` is high exactly while the channel's reversal flag and `irq_en[n]` are both 1.
- R8: The compare flag sets when an up-only event makes the count equal the reload value.
- R9: Reaching the reload value by an ordinary down count leaves the compare flag clear. The reload performed on underflow sets it.
- R10: The compare flag sets when `run` rises while the count already equals the reload value. It clears on its strobe, and a set in the same cycle wins.
- R11: With `mode_wide`=0 the two channels are independent. Channel 0 uses bits 7:0 of `count_val` and `reload_val`; channel 1 uses bits 15:8.
- R12: With `mode_wide`=1 the block is one 16-bit counter on all 16 bits, driven only by the channel 0 inputs and controls. Channel 1 inputs and controls are ignored: its code and flags hold and `irq[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 0: two 8-bit channels, 1: one 16-bit channel |
| run | input | 2 | Per-channel count enable; its rise is the counting start |
| up_evt | input | 2 | Per-channel up strobe |
| dn_evt | input | 2 | Per-channel down strobe |
| reload_val | input | 16 | Reload/compare value (ch0 low byte, ch1 high byte when split) |
| irq_en | input | 2 | Per-channel interrupt enable |
| clr_dir_chg | input | 2 | Write-one clear strobes for the reversal flags |
| clr_cmp_hit | input | 2 | Write-one clear strobes for the compare flags |
| count_val | output | 16 | Count value (ch0 low byte, ch1 high byte when split) |
| dir_code0 | output | 2 | Channel 0 direction code |
| dir_code1 | output | 2 | Channel 1 direction code |
| dir_chg | output | 2 | Sticky reversal flags |
| cmp_hit | output | 2 | Compare flags |
| irq | output | 2 | Interrupt requests |

## Verification
The bench targets the edges of the compare rules. It walks a count down onto the reload value, which must not set the compare flag; a design that compared in both directions would set it. It also forces an underflow reload, which must set the flag even though the count moved down. Simultaneous up and down strobes are applied at zero, where a design that treated them as a down count would perform a spurious reload. A reversal flag cleared in the same cycle as a new reversal must stay set. The byte carry and the 65535 wrap in 16-bit mode are checked while channel 1 strobes are applied; a design that let channel 1 leak through would disturb the upper byte or raise `irq[1]`.

// File: rtl/updn_pkg.sv
package updn_pkg;
    // Direction state doubles as the two-bit direction code
    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_DOWN = 2'b01,
        DIR_UP   = 2'b10,
        DIR_BOTH = 2'b11
    } dir_e;
endpackage

// File: rtl/updn_dir_track.sv
module updn_dir_track
    import updn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       up,
    input  logic       dn,
    input  logic       clr_chg,
    input  logic       irq_en,
    output logic [1:0] code,
    output logic       chg_flag,
    output logic       irq
);
    dir_e state, state_nxt;
    dir_e ev_dir;
    logic reversal;

    assign ev_dir = dir_e'({up, dn});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= DIR_NONE;
        else        state <= state_nxt;
    end

    // next state and reversal detection
    always_comb begin
        state_nxt = state;
        reversal  = 1'b0;
        if (run && (up || dn)) begin
            unique case (state)
                DIR_NONE: state_nxt = ev_dir;                 // FIRST_COUNT
                DIR_DOWN: begin
                    state_nxt = ev_dir;
                    reversal  = (ev_dir == DIR_UP);           // REVERSE_UP
                end
                DIR_UP: begin
                    state_nxt = ev_dir;
                    reversal  = (ev_dir == DIR_DOWN);         // REVERSE_DOWN
                end
                DIR_BOTH: state_nxt = ev_dir;                 // LEAVE_BOTH / TO_BOTH
            endcase
        end
    end

    // outputs: sticky reversal flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        chg_flag <= 1'b0;
        else if (reversal) chg_flag <= 1'b1;
        else if (clr_chg)  chg_flag <= 1'b0;
    end

    assign code = state;
    assign irq  = chg_flag & irq_en;

    p_up_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && !dn) |=> (code == 2'b10));
    p_both_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && dn) |=> (code == 2'b11));
    p_chg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !clr_chg) |=> chg_flag);
    p_rev_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 2'b10 && run && dn && !up) |=> chg_flag);
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         narrow,
    input  logic         run,
    input  logic         up,
    input  logic         dn,
    input  logic [W-1:0] reload,
    input  logic         clr_cmp,
    output logic [W-1:0] cnt,
    output logic         cmp_flag
);
    localparam logic [W-1:0] FULL_MAX   = '1;
    localparam logic [W-1:0] NARROW_MAX = FULL_MAX >> (W - NW);

    logic [W-1:0] lim, cnt_nxt;
    logic         run_q, start, up_only, dn_only, hit;

    assign lim     = narrow ? NARROW_MAX : FULL_MAX;
    assign start   = run & ~run_q;
    assign up_only = run & up & ~dn;
    assign dn_only = run & dn & ~up;

    always_comb begin
        cnt_nxt = cnt;
        hit     = 1'b0;
        if (up_only) begin
            cnt_nxt = (cnt == lim) ? '0 : cnt + 1'b1;
            hit     = (cnt_nxt == reload);
        end else if (dn_only) begin
            if (cnt == '0) begin
                cnt_nxt = reload;
                hit     = 1'b1;
            end else begin
                cnt_nxt = cnt - 1'b1;
            end
        end
        if (start && cnt == reload) hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            run_q    <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            run_q <= run;
            if (hit)          cmp_flag <= 1'b1;
            else if (clr_cmp) cmp_flag <= 1'b0;
        end
    end

    p_both_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && dn) |=> (cnt == $past(cnt)));
    p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && !dn && cnt == lim) |=> (cnt == '0));
    p_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dn && !up && cnt == '0) |=> (cnt == $past(reload)));
    p_down_no_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_only && cnt != '0 && !start && !cmp_flag) |=> !cmp_flag);
endmodule

// File: rtl/updn_pair_counter.sv
module updn_pair_counter #(
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wide,
    input  logic [1:0]          run,
    input  logic [1:0]          up_evt,
    input  logic [1:0]          dn_evt,
    input  logic [2*CH_W-1:0]   reload_val,
    input  logic [1:0]          irq_en,
    input  logic [1:0]          clr_dir_chg,
    input  logic [1:0]          clr_cmp_hit,
    output logic [2*CH_W-1:0]   count_val,
    output logic [1:0]          dir_code0,
    output logic [1:0]          dir_code1,
    output logic [1:0]          dir_chg,
    output logic [1:0]          cmp_hit,
    output logic [1:0]          irq
);
    localparam int WIDE_W = 2 * CH_W;

    logic [WIDE_W-1:0] cnt0, reload0;
    logic [CH_W-1:0]   cnt1;
    logic              split;
    logic              run1, up1, dn1, clr_chg1, clr_cmp1, en1;

    assign split    = ~mode_wide;
    assign reload0  = mode_wide ? reload_val : {{CH_W{1'b0}}, reload_val[CH_W-1:0]};
    // channel 1 controls and inputs are muted in wide mode
    assign run1     = run[1]         & split;
    assign up1      = up_evt[1]      & split;
    assign dn1      = dn_evt[1]      & split;
    assign clr_chg1 = clr_dir_chg[1] & split;
    assign clr_cmp1 = clr_cmp_hit[1] & split;
    assign en1      = irq_en[1]      & split;

    updn_count_core #(.W(WIDE_W), .NW(CH_W)) u_core0 (
        .clk(clk), .rst_n(rst_n), .narrow(split), .run(run[0]),
        .up(up_evt[0]), .dn(dn_evt[0]), .reload(reload0),
        .clr_cmp(clr_cmp_hit[0]), .cnt(cnt0), .cmp_flag(cmp_hit[0])
    );

    updn_count_core #(.W(CH_W), .NW(CH_W)) u_core1 (
        .clk(clk), .rst_n(rst_n), .narrow(1'b0), .run(run1),
        .up(up1), .dn(dn1), .reload(reload_val[WIDE_W-1:CH_W]),
        .clr_cmp(clr_cmp1), .cnt(cnt1), .cmp_flag(cmp_hit[1])
    );

    updn_dir_track u_dir0 (
        .clk(clk), .rst_n(rst_n), .run(run[0]), .up(up_evt[0]), .dn(dn_evt[0]),
        .clr_chg(clr_dir_chg[0]), .irq_en(irq_en[0]),
        .code(dir_code0), .chg_flag(dir_chg[0]), .irq(irq[0])
    );

    updn_dir_track u_dir1 (
        .clk(clk), .rst_n(rst_n), .run(run1), .up(up1), .dn(dn1),
        .clr_chg(clr_chg1), .irq_en(en1),
        .code(dir_code1), .chg_flag(dir_chg[1]), .irq(irq[1])
    );

    assign count_val = mode_wide ? cnt0 : {cnt1, cnt0[CH_W-1:0]};

    p_wide_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wide |=> ($stable(cnt1) && $stable(dir_code1) && $stable(cmp_hit[1])));
    p_split_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wide && !run[0]) |=> (count_val[CH_W-1:0] == $past(count_val[CH_W-1:0])));
endmodule

// File: tb/updn_pair_counter_test.sv
`timescale 1ns/1ps
module updn_pair_counter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_wide;
    logic [1:0]  run, up_evt, dn_evt, irq_en, clr_dir_chg, clr_cmp_hit;
    logic [15:0] reload_val;
    logic [15:0] count_val;
    logic [1:0]  dir_code0, dir_code1, dir_chg, cmp_hit, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    updn_pair_counter uut (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .run(run),
        .up_evt(up_evt), .dn_evt(dn_evt), .reload_val(reload_val),
        .irq_en(irq_en), .clr_dir_chg(clr_dir_chg), .clr_cmp_hit(clr_cmp_hit),
        .count_val(count_val), .dir_code0(dir_code0), .dir_code1(dir_code1),
        .dir_chg(dir_chg), .cmp_hit(cmp_hit), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // apply strobes for one clock, then release them; results are visible afterwards
    task automatic step(input logic [1:0] u, input logic [1:0] d,
                        input logic [1:0] cc, input logic [1:0] cm);
        up_evt = u; dn_evt = d; clr_dir_chg = cc; clr_cmp_hit = cm;
        @(negedge clk);
        up_evt = 2'b00; dn_evt = 2'b00; clr_dir_chg = 2'b00; clr_cmp_hit = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_wide = 1'b0; run = 2'b00; up_evt = 2'b00; dn_evt = 2'b00;
        irq_en = 2'b00; clr_dir_chg = 2'b00; clr_cmp_hit = 2'b00; reload_val = 16'h0000;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk("R1 count", count_val, 16'h0000);
        chk("R1 codes", {12'h0, dir_code1, dir_code0}, 16'h0000);
        chk("R1 flags", {10'h0, dir_chg, cmp_hit, irq}, 16'h0000);
    endtask

    task automatic t_up_compare();
        do_reset();
        reload_val = 16'h0305; run = 2'b11;
        for (int i = 0; i < 3; i++) step(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R5 count after 3 ups", count_val, 16'h0003);
        chk("R5 code0 up", {14'h0, dir_code0}, 16'h0002);
        chk("R11 ch1 untouched", {14'h0, dir_code1}, 16'h0000);
        chk("R8 no match yet", {15'h0, cmp_hit[0]}, 16'h0000);
        for (int i = 0; i < 2; i++) step(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R8 up match", {14'h0, cmp_hit}, 16'h0001);
        run = 2'b10;
        step(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R5 stopped count", count_val, 16'h0005);
    endtask

    task automatic t_down_rules();
        do_reset();
        reload_val = 16'h0005; run = 2'b01; irq_en = 2'b01;
        for (int i = 0; i < 6; i++) step(2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b00, 2'b00, 2'b00, 2'b01);
        chk("R10 cmp cleared", {15'h0, cmp_hit[0]}, 16'h0000);
        chk("R6 no reversal yet", {15'h0, dir_chg[0]}, 16'h0000);
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R9 down reach count", count_val, 16'h0005);
        chk("R9 down no cmp", {15'h0, cmp_hit[0]}, 16'h0000);
        chk("R6 reversal set", {15'h0, dir_chg[0]}, 16'h0001);
        chk("R7 irq on", {14'h0, irq}, 16'h0001);
        irq_en = 2'b00; #1;
        chk("R7 irq masked", {14'h0, irq}, 16'h0000);
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R6 sticky", {15'h0, dir_chg[0]}, 16'h0001);
        step(2'b00, 2'b00, 2'b01, 2'b00);
        chk("R6 cleared", {15'h0, dir_chg[0]}, 16'h0000);
        step(2'b01, 2'b00, 2'b01, 2'b00);
        chk("R6 set wins", {15'h0, dir_chg[0]}, 16'h0001);
        chk("R8 up match again", {15'h0, cmp_hit[0]}, 16'h0001);
    endtask

    task automatic t_both();
        do_reset();
        reload_val = 16'h0909; run = 2'b11;
        step(2'b01, 2'b00, 2'b00, 2'b00);
        step(2'b11, 2'b11, 2'b00, 2'b00);
        chk("R4 count held", count_val, 16'h0001);
        chk("R4 codes both", {12'h0, dir_code1, dir_code0}, 16'h000F);
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R6 leave both no flag", {14'h0, dir_chg}, 16'h0000);
        chk("R5 code0 down", {14'h0, dir_code0}, 16'h0001);
        chk("R4 ch1 no reload", count_val, 16'h0000);
    endtask

    task automatic t_underflow_wrap();
        do_reset();
        reload_val = 16'hFF03; run = 2'b11;
        step(2'b00, 2'b10, 2'b00, 2'b00);
        chk("R3 ch1 reload", count_val, 16'hFF00);
        chk("R9 underflow cmp", {14'h0, cmp_hit}, 16'h0002);
        step(2'b10, 2'b00, 2'b00, 2'b00);
        chk("R2 ch1 wrap 255", count_val, 16'h0000);
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R11 ch0 reload", count_val, 16'h0003);
        chk("R9 ch0 underflow cmp", {14'h0, cmp_hit}, 16'h0003);
    endtask

    task automatic t_start_compare();
        do_reset();
        reload_val = 16'h0007; run = 2'b11;
        @(negedge clk);
        chk("R10 start match", {14'h0, cmp_hit}, 16'h0002);
        run = 2'b00; reload_val = 16'h0000;
        @(negedge clk);
        run = 2'b01;
        step(2'b00, 2'b00, 2'b00, 2'b01);
        chk("R10 start beats clear", {15'h0, cmp_hit[0]}, 16'h0001);
    endtask

    task automatic t_wide();
        do_reset();
        mode_wide = 1'b1; reload_val = 16'h00FF; run = 2'b11; irq_en = 2'b11;
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R12 wide reload", count_val, 16'h00FF);
        step(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R12 byte carry", count_val, 16'h0100);
        chk("R12 irq ch1 off", {14'h0, irq}, 16'h0001);
        step(2'b10, 2'b00, 2'b00, 2'b00);
        step(2'b00, 2'b10, 2'b00, 2'b00);
        chk("R12 ch1 strobes ignored", count_val, 16'h0100);
        chk("R12 ch1 code held", {14'h0, dir_code1}, 16'h0000);
        do_reset();
        mode_wide = 1'b1; reload_val = 16'hFFFF; run = 2'b01;
        step(2'b00, 2'b01, 2'b00, 2'b00);
        chk("R3 wide underflow", count_val, 16'hFFFF);
        step(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R2 wrap 65535", count_val, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset_state();
        t_up_compare();
        t_down_rules();
        t_both();
        t_underflow_wrap();
        t_start_compare();
        t_wide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule